// File: doc/BRIEF.md
# Continuously Variable Slope Delta Codec Core

This block is a full-duplex, all-digital delta modulation codec whose step size follows the loudness of the signal. The encoder accepts one signed PCM sample per bit-clock enable. It compares the sample with its own running reconstruction, emits a single bit, and nudges the reconstruction up or down by the current step. The decoder accepts one received bit per enable and rebuilds the same reconstruction, which it presents as a signed PCM sample.

Both directions adapt their step the same way. A short history of emitted bits is searched for a run of identical bits, of three or four bits as chosen at run time. Each detected run pumps a leaky syllabic accumulator, and the step is a minimum value plus a scaled copy of that accumulator, clamped to a ceiling that is about fifty times the minimum. The reconstruction itself is a leaky integrator that saturates at full scale. A rate select picks the leak shifts for 16, 32 or 64 kbit/s operation, so that the integrator corner stays near 275 Hz and the syllabic time constant stays near 4 ms. Each direction has its own clock enable and an active-low force-idle input that replaces its bit stream with an alternating pattern.

Top module: `cvsd_codec`

## Requirements
- R1: A synchronous active-high reset clears both integrators to 0, both syllabic accumulators to 0 and both bit histories to zero bits, and sets `enc_bit_o` to 0. The first bit after reset therefore moves the reconstruction by exactly STEP_MIN.
- R2: On a cycle with `enc_ce` high and `enc_idle_n` high, the encoder emits 1 when the signed `enc_pcm_i` is greater than or equal to its reconstruction, and 0 otherwise. `enc_bit_o` is registered and shows the new bit from the next clock edge.
- R3: On each enabled bit, the reconstruction y becomes y - (y >>> L) + step for a 1 and y - (y >>> L) - step for a 0. Here >>> is an arithmetic shift, and step is the value from before this bit's accumulator update. `dec_pcm_o` shows the decoder reconstruction.
- R4: A run is detected when the new bit equals the previous two bits (`alg3_sel` = 1) or the previous three bits (`alg3_sel` = 0). The zero bits left by reset count as history.
- R5: On each enabled bit, the accumulator s becomes s - (s >> S), plus SYL_INC when a run was detected, saturating at 2^SYL_W - 1. The step is min(STEP_MIN + (s >> STEP_SH), STEP_MAX).
- R6: `rate_sel` 0, 1 and 2 (and 3) select L = LEAK_BASE + 0, +1 and +2 (+2), and S = SYL_BASE + 0, +1 and +2 (+2).
- R7: The reconstruction saturates at the signed limits 2^(PCM_W-1) - 1 and -2^(PCM_W-1) and never wraps.
- R8: While `enc_idle_n` is low, each enabled encoder bit is the inverse of the previously emitted bit, whatever `enc_pcm_i` holds. The encoder state advances with that bit.
- R9: While `dec_idle_n` is low, `dec_bit_i` is ignored and the decoder uses the inverse of its previous bit in its place. The decoder output then settles close to zero.
- R10: While a direction's enable is low, its state and output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alg3_sel | input | 1 | 1: run of 3 bits, 0: run of 4 bits |
| rate_sel | input | 2 | Bit-rate code selecting leak shifts |
| enc_ce | input | 1 | Encoder bit enable |
| enc_idle_n | input | 1 | Active-low encoder force idle |
| enc_pcm_i | input | PCM_W | Signed PCM sample to encode |
| enc_bit_o | output | 1 | Encoded bit |
| dec_ce | input | 1 | Decoder bit enable |
| dec_idle_n | input | 1 | Active-low decoder force idle |
| dec_bit_i | input | 1 | Received bit |
| dec_pcm_o | output | PCM_W | Signed reconstructed sample |

## Verification
The bench builds the codec with PCM_W = 12 and all other parameters at their defaults. The narrow word puts the saturation limits of 2047 and -2048 below the level where the leak balances a clamped step of 800. That lets long runs of ones and zeros drive the reconstruction into both rails. The clamped step is then visible in the first opposite bit, and the other cases stay hand-countable: the run length, the rate-dependent leak and idle settling.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

    typedef enum logic [1:0] {
        RATE_LOW      = 2'd0,
        RATE_MID      = 2'd1,
        RATE_HIGH     = 2'd2,
        RATE_HIGH_ALT = 2'd3
    } rate_e;

    // Bit selected for one enabled cycle, with the run flag it produced.
    typedef struct packed {
        logic bit_v;
        logic run;
    } cvsd_bit_t;

    // Extra shift added to the base leak shifts for each rate code.
    function automatic logic [1:0] rate_idx(input rate_e r);
        return (r == RATE_HIGH_ALT) ? 2'd2 : 2'(r);
    endfunction

    function automatic logic [4:0] leak_shift(input int base, input rate_e r);
        return 5'(base) + 5'(rate_idx(r));
    endfunction

endpackage

// File: rtl/cvsd_run_detect.sv
module cvsd_run_detect #(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic short_sel,
    input  logic bit_i,
    output logic run_o,
    output logic prev_o
);
    localparam int HW = RUN_LONG - 1;

    logic [HW-1:0] hist_q;
    logic          match_s;
    logic          match_l;

    always_comb begin
        match_s = 1'b1;
        match_l = 1'b1;
        for (int i = 0; i < HW; i++) begin
            if (hist_q[i] != bit_i) begin
                match_l = 1'b0;
                if (i < RUN_SHORT - 1) match_s = 1'b0;
            end
        end
        run_o = short_sel ? match_s : match_l;
    end

    assign prev_o = hist_q[0];

    always_ff @(posedge clk) begin
        if (rst)     hist_q <= '0;
        else if (ce) hist_q <= {hist_q[HW-2:0], bit_i};
    end
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic
    import cvsd_pkg::*;
#(
    parameter int SYL_W    = 16,
    parameter int SYL_INC  = 1024,
    parameter int SYL_BASE = 6,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 800,
    parameter int STEP_SH  = 4,
    parameter int STEP_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  rate_e             rate,
    input  logic              run_i,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [SYL_W:0] INC_V = (SYL_W+1)'(SYL_INC);
    localparam logic [SYL_W:0] MAX_V = (SYL_W+1)'(STEP_MAX);

    logic [SYL_W-1:0] s_q;
    logic [SYL_W-1:0] decay;
    logic [SYL_W:0]   nxt;
    logic [SYL_W:0]   raw;
    logic [4:0]       sh;

    always_comb begin
        sh    = leak_shift(SYL_BASE, rate);
        decay = s_q - (s_q >> sh);
        nxt   = {1'b0, decay} + (run_i ? INC_V : '0);
        raw   = (SYL_W+1)'(STEP_MIN) + (SYL_W+1)'(s_q >> STEP_SH);
        step_o = (raw > MAX_V) ? STEP_W'(STEP_MAX) : raw[STEP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else if (ce) begin
            s_q <= nxt[SYL_W] ? '1 : nxt[SYL_W-1:0];
        end
    end
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator
    import cvsd_pkg::*;
#(
    parameter int PCM_W     = 16,
    parameter int STEP_W    = 10,
    parameter int LEAK_BASE = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  rate_e                   rate,
    input  logic                    up_i,
    input  logic [STEP_W-1:0]       step_i,
    output logic signed [PCM_W-1:0] y_o
);
    localparam int EW = PCM_W + 2;
    localparam logic signed [EW-1:0] MAXV = {{3{1'b0}}, {(PCM_W-1){1'b1}}};
    localparam logic signed [EW-1:0] MINV = {{3{1'b1}}, {(PCM_W-1){1'b0}}};

    logic signed [PCM_W-1:0] y_q;
    logic signed [EW-1:0]    delta;
    logic signed [EW-1:0]    sum;
    logic [4:0]              sh;

    always_comb begin
        sh    = leak_shift(LEAK_BASE, rate);
        delta = signed'({{(EW-STEP_W){1'b0}}, step_i});
        sum   = EW'(y_q) - EW'(y_q >>> sh) + (up_i ? delta : -delta);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
        end else if (ce) begin
            if (sum > MAXV)      y_q <= MAXV[PCM_W-1:0];
            else if (sum < MINV) y_q <= MINV[PCM_W-1:0];
            else                 y_q <= sum[PCM_W-1:0];
        end
    end

    assign y_o = y_q;
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec
    import cvsd_pkg::*;
#(
    parameter int PCM_W     = 16,
    parameter int SYL_W     = 16,
    parameter int SYL_INC   = 1024,
    parameter int SYL_BASE  = 6,
    parameter int LEAK_BASE = 3,
    parameter int STEP_MIN  = 16,
    parameter int STEP_MAX  = 800,
    parameter int STEP_SH   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alg3_sel,
    input  logic [1:0]       rate_sel,
    input  logic             enc_ce,
    input  logic             enc_idle_n,
    input  logic [PCM_W-1:0] enc_pcm_i,
    output logic             enc_bit_o,
    input  logic             dec_ce,
    input  logic             dec_idle_n,
    input  logic             dec_bit_i,
    output logic [PCM_W-1:0] dec_pcm_o
);
    localparam int STEP_W = $clog2(STEP_MAX + 1);

    rate_e rate;
    assign rate = rate_e'(rate_sel);

    cvsd_bit_t               enc_sel, dec_sel;
    logic                    enc_prev, dec_prev;
    logic [STEP_W-1:0]       enc_step, dec_step;
    logic signed [PCM_W-1:0] enc_y, dec_y;
    logic                    enc_bit_q;

    // Bit choice: normal decision or the inverse of the last bit when idle.
    assign enc_sel.bit_v = enc_idle_n ? ($signed(enc_pcm_i) >= enc_y) : ~enc_prev;
    assign dec_sel.bit_v = dec_idle_n ? dec_bit_i : ~dec_prev;

    cvsd_run_detect u_enc_run (
        .clk(clk), .rst(rst), .ce(enc_ce), .short_sel(alg3_sel),
        .bit_i(enc_sel.bit_v), .run_o(enc_sel.run), .prev_o(enc_prev)
    );
    cvsd_run_detect u_dec_run (
        .clk(clk), .rst(rst), .ce(dec_ce), .short_sel(alg3_sel),
        .bit_i(dec_sel.bit_v), .run_o(dec_sel.run), .prev_o(dec_prev)
    );

    cvsd_syllabic #(
        .SYL_W(SYL_W), .SYL_INC(SYL_INC), .SYL_BASE(SYL_BASE),
        .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_SH(STEP_SH), .STEP_W(STEP_W)
    ) u_enc_syl (
        .clk(clk), .rst(rst), .ce(enc_ce), .rate(rate),
        .run_i(enc_sel.run), .step_o(enc_step)
    );
    cvsd_syllabic #(
        .SYL_W(SYL_W), .SYL_INC(SYL_INC), .SYL_BASE(SYL_BASE),
        .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_SH(STEP_SH), .STEP_W(STEP_W)
    ) u_dec_syl (
        .clk(clk), .rst(rst), .ce(dec_ce), .rate(rate),
        .run_i(dec_sel.run), .step_o(dec_step)
    );

    cvsd_integrator #(.PCM_W(PCM_W), .STEP_W(STEP_W), .LEAK_BASE(LEAK_BASE)) u_enc_int (
        .clk(clk), .rst(rst), .ce(enc_ce), .rate(rate),
        .up_i(enc_sel.bit_v), .step_i(enc_step), .y_o(enc_y)
    );
    cvsd_integrator #(.PCM_W(PCM_W), .STEP_W(STEP_W), .LEAK_BASE(LEAK_BASE)) u_dec_int (
        .clk(clk), .rst(rst), .ce(dec_ce), .rate(rate),
        .up_i(dec_sel.bit_v), .step_i(dec_step), .y_o(dec_y)
    );

    always_ff @(posedge clk) begin
        if (rst)         enc_bit_q <= 1'b0;
        else if (enc_ce) enc_bit_q <= enc_sel.bit_v;
    end

    assign enc_bit_o = enc_bit_q;
    assign dec_pcm_o = dec_y;
endmodule

// File: rtl/cvsd_codec_chk.sv
module cvsd_codec_chk #(
    parameter int PCM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enc_ce,
    input logic             enc_idle_n,
    input logic             enc_bit_o,
    input logic             dec_ce,
    input logic             dec_idle_n,
    input logic             dec_bit_i,
    input logic [PCM_W-1:0] dec_pcm_o
);
    // R1: reset leaves the outputs cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dec_pcm_o == '0 && !enc_bit_o));

    // R8: forced-idle encoder alternates its output
    p_enc_idle_alt_r8: assert property (@(posedge clk) disable iff (rst)
        (enc_ce && !enc_idle_n) |=> (enc_bit_o != $past(enc_bit_o)));

    // R10: disabled directions hold
    p_dec_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !dec_ce |=> $stable(dec_pcm_o));
    p_enc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !enc_ce |=> $stable(enc_bit_o));

    // R7: no wrap in either direction
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_ce && dec_idle_n && dec_bit_i && !dec_pcm_o[PCM_W-1]) |=> !dec_pcm_o[PCM_W-1]);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_ce && dec_idle_n && !dec_bit_i && dec_pcm_o[PCM_W-1]) |=> dec_pcm_o[PCM_W-1]);
endmodule

bind cvsd_codec cvsd_codec_chk #(.PCM_W(PCM_W)) u_chk (
    .clk(clk), .rst(rst), .enc_ce(enc_ce), .enc_idle_n(enc_idle_n),
    .enc_bit_o(enc_bit_o), .dec_ce(dec_ce), .dec_idle_n(dec_idle_n),
    .dec_bit_i(dec_bit_i), .dec_pcm_o(dec_pcm_o)
);

// File: tb/cvsd_codec_bench.sv
`timescale 1ns/1ps
module cvsd_codec_bench;
    localparam int PW   = 12;
    localparam int YMAX = 2047;
    localparam int YMIN = -2048;
    localparam int VEC [5][2] = '{'{1, 16}, '{1, 30}, '{1, 43}, '{1, 118}, '{0, -39}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alg3_sel = 1'b1;
    logic [1:0]    rate_sel = 2'd0;
    logic          enc_ce = 1'b0;
    logic          enc_idle_n = 1'b1;
    logic [PW-1:0] enc_pcm_i = '0;
    logic          enc_bit_o;
    logic          dec_ce = 1'b0;
    logic          dec_idle_n = 1'b1;
    logic          dec_bit_i = 1'b0;
    logic [PW-1:0] dec_pcm_o;

    int checks = 0;
    int fails = 0;
    int dy, ds, dh, ey, es, eh;
    bit done = 0;

    cvsd_codec #(.PCM_W(PW)) u_cvsd_codec (
        .clk(clk), .rst(rst), .alg3_sel(alg3_sel), .rate_sel(rate_sel),
        .enc_ce(enc_ce), .enc_idle_n(enc_idle_n), .enc_pcm_i(enc_pcm_i),
        .enc_bit_o(enc_bit_o), .dec_ce(dec_ce), .dec_idle_n(dec_idle_n),
        .dec_bit_i(dec_bit_i), .dec_pcm_o(dec_pcm_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pcm_now();
        return int'($signed(dec_pcm_o));
    endfunction

    task automatic model(inout int y, inout int s, inout int h, input int b);
        int r, l, sh, step, run;
        r    = (rate_sel == 2'd3) ? 2 : int'(rate_sel);
        l    = 3 + r;
        sh   = 6 + r;
        run  = alg3_sel ? ((h & 3) == (b ? 3 : 0)) : ((h & 7) == (b ? 7 : 0));
        step = 16 + (s >> 4);
        if (step > 800) step = 800;
        y = y - (y >>> l) + (b ? step : -step);
        if (y > YMAX) y = YMAX;
        if (y < YMIN) y = YMIN;
        s = s - (s >> sh) + (run ? 1024 : 0);
        if (s > 65535) s = 65535;
        h = ((h << 1) | b) & 7;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        dy = 0; ds = 0; dh = 0; ey = 0; es = 0; eh = 0;
    endtask

    task automatic dec_pulse(input int rx);
        int b;
        b = dec_idle_n ? rx : ((dh & 1) ^ 1);
        @(negedge clk);
        dec_bit_i = rx[0];
        dec_ce = 1'b1;
        @(negedge clk);
        dec_ce = 1'b0;
        model(dy, ds, dh, b);
    endtask

    task automatic enc_pulse(input int x, output int b);
        b = enc_idle_n ? int'(x >= ey) : ((eh & 1) ^ 1);
        @(negedge clk);
        enc_pcm_i = x[PW-1:0];
        enc_ce = 1'b1;
        @(negedge clk);
        enc_ce = 1'b0;
        model(ey, es, eh, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int b, prev, x;
        do_reset();
        chk("R1 dec_pcm_o after reset", pcm_now(), 0);
        chk("R1 enc_bit_o after reset", int'(enc_bit_o), 0);

        // R3 R4 R5: hand-counted decoder vectors, run of 3, rate code 0
        for (int k = 0; k < 5; k++) begin
            dec_pulse(VEC[k][0]);
            chk("R3 vector decode", pcm_now(), VEC[k][1]);
        end

        // R10: disabled decoder and encoder hold
        dec_bit_i = 1'b1;
        enc_pcm_i = 12'd2000;
        repeat (6) @(negedge clk);
        chk("R10 decoder holds", pcm_now(), -39);
        chk("R10 encoder holds", int'(enc_bit_o), 0);

        // R4: run of 4
        do_reset();
        alg3_sel = 1'b0;
        for (int k = 0; k < 3; k++) dec_pulse(1);
        chk("R4 run4 third bit", pcm_now(), 43);
        dec_pulse(1);
        chk("R4 run4 fourth bit", pcm_now(), 54);
        dec_pulse(1);
        chk("R4 run4 fifth bit", pcm_now(), 128);
        alg3_sel = 1'b1;

        // R6: rate code 2 uses a longer leak
        do_reset();
        rate_sel = 2'd2;
        for (int k = 0; k < 3; k++) dec_pulse(1);
        chk("R6 rate2 leak", pcm_now(), 47);
        for (int k = 0; k < 40; k++) dec_pulse(k % 3 == 0 ? 0 : 1);
        chk("R6 rate2 model", pcm_now(), dy);
        rate_sel = 2'd3;
        for (int k = 0; k < 40; k++) dec_pulse(k % 5 == 0 ? 0 : 1);
        chk("R6 rate3 model", pcm_now(), dy);
        rate_sel = 2'd1;
        for (int k = 0; k < 40; k++) dec_pulse(k % 4 < 2 ? 1 : 0);
        chk("R6 rate1 model", pcm_now(), dy);

        // R7 R5: saturation and step clamp
        do_reset();
        rate_sel = 2'd0;
        for (int k = 0; k < 400; k++) dec_pulse(1);
        chk("R7 positive rail", pcm_now(), YMAX);
        dec_pulse(0);
        chk("R5 clamped step", pcm_now(), 992);
        for (int k = 0; k < 400; k++) dec_pulse(0);
        chk("R7 negative rail", pcm_now(), YMIN);

        // R9: forced-idle decoder ignores input and settles
        dec_idle_n = 1'b0;
        for (int k = 0; k < 600; k++) dec_pulse(1);
        chk("R9 idle model", pcm_now(), dy);
        chk("R9 idle near zero", int'(pcm_now() <= 64 && pcm_now() >= -64), 1);
        dec_idle_n = 1'b1;

        // R2: encoder on a sawtooth
        do_reset();
        for (int k = 0; k < 300; k++) begin
            x = ((k * 53) % 3000) - 1500;
            enc_pulse(x, b);
            chk("R2 encoder bit", int'(enc_bit_o), b);
        end

        // R8: forced-idle encoder alternates regardless of input
        enc_idle_n = 1'b0;
        prev = int'(enc_bit_o);
        for (int k = 0; k < 40; k++) begin
            enc_pulse(2047, b);
            chk("R8 idle alternate", int'(enc_bit_o), prev ^ 1);
            prev = int'(enc_bit_o);
        end
        enc_idle_n = 1'b1;
        for (int k = 0; k < 60; k++) begin
            enc_pulse(800 - k * 20, b);
            chk("R8 resume after idle", int'(enc_bit_o), b);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule